// File: doc/BRIEF.md
# Memory-Reference Effective Address Generator

This block turns a 32-bit memory-reference instruction into the byte address of its operand. It splits the instruction into its fields and picks an operand size class from the opcode. When the index field is nonzero it reads one index register through a register-file read port. When the indirect flag is set it reads one memory word through a request/acknowledge port, and the low address bits of that word become the new reference address. The index is then added, scaled so that an index value k lands on the k-th operand of the selected size. The result is a 19-bit byte address, the operand size, and flags telling the execution stage that the operand lies in the general registers or that a doubleword address was odd.

Opcodes of the immediate type skip address formation altogether. For these the block returns a sign-extended 20-bit operand. If such an instruction also carries the indirect flag, it is reported as nonexistent. An instruction is accepted on `start` while the block is idle. One cycle later, or later if an index read or an indirect fetch is needed, `done` pulses with all results valid. The results hold until the next `done`.

Top module: `ea_gen`

## Requirements
- R1: Instruction bit numbering uses port indices. instr[31] is the indirect flag, instr[30:24] the 7-bit opcode, instr[23:20] the R field (returned on `dst_reg`), instr[19:17] the index select X, and instr[16:0] the 17-bit word reference address. A direct instruction with X = 0 raises `done` in the first cycle after `start`, with `ea_addr` = reference address × 4.
- R2: When X is nonzero, index register X is read through `rf_sel`/`rf_data` and `done` follows two cycles after `start` for a direct reference. When X = 0, no index is added, whatever register 0 holds.
- R3: The size class comes from a four-entry table indexed by opcode[1:0]. By default 0 is word, 1 is doubleword, 2 is halfword and 3 is byte. The `op_size` encoding is 0 byte, 1 halfword, 2 word, 3 doubleword. The index k adds k × 1, 2, 4 or 8 bytes for byte, halfword, word or doubleword, and the sum wraps at 19 bits.
- R4: With the indirect flag set on a non-immediate opcode, exactly one fetch is made. `mem_req` rises with `mem_addr` = reference address and both hold until `mem_ack`. `mem_rword` (the fetched word's low 17 bits) replaces the reference address, and indexing is applied afterwards.
- R5: Opcodes 0x02, 0x20, 0x21, 0x22 and 0x23 are immediate. They raise `is_imm`, return `imm_val` = instr[19:0] sign-extended from instr[19], report size word and `ea_addr` = 0, make no memory request, and finish one cycle after `start`.
- R6: An immediate opcode with the indirect flag set raises `nonexist`. No other instruction does.
- R7: `reg_operand` is 1 exactly when a non-immediate effective word address (ea_addr[18:2]) is below 16.
- R8: For doubleword operands, `ea_addr[2:0]` is forced to 0. `dw_odd` is raised when the unforced byte address had bit 2 set.
- R9: `done` is a single-cycle pulse, and the results hold their values after it.
- R10: During and straight after reset, `done` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept `instr` (honoured only when idle) |
| instr | input | 32 | Instruction word |
| rf_sel | output | 3 | Index register number being read (0 when not reading) |
| rf_data | input | 19 | Low 19 bits of the selected index register |
| mem_req | output | 1 | Indirect word fetch request |
| mem_addr | output | 17 | Word address of the indirect fetch |
| mem_ack | input | 1 | Fetch data valid |
| mem_rword | input | 17 | Low 17 bits of the fetched word |
| done | output | 1 | Results valid pulse |
| ea_addr | output | 19 | Effective byte address |
| op_size | output | 2 | Operand size class |
| dst_reg | output | 4 | R field of the instruction |
| reg_operand | output | 1 | Operand lies in the general registers |
| dw_odd | output | 1 | Doubleword address was odd |
| is_imm | output | 1 | Immediate-type instruction |
| imm_val | output | 32 | Sign-extended immediate operand |
| nonexist | output | 1 | Nonexistent instruction flag |

## Verification
The bench targets the edges of index scaling. It uses a nonzero register 0 with X = 0: a design that indexes through register 0 returns a shifted address. Each size class is tried with the same index: a wrong scale shifts the byte address by a power of two. Indirect fetches are combined with indexing and random acknowledge delays: a design that indexes before the fetch, or drops the request early, returns the wrong address or never finishes. The word addresses 15 and 16 bound the register flag, and odd doubleword references must come back aligned and flagged. Immediate opcodes with and without the indirect flag and with negative fields catch a missed sign extension or a stray memory request.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
    localparam int INSTR_W    = 32;
    localparam int REF_W      = 17;
    localparam int BYTE_W     = REF_W + 2;
    localparam int OPC_W      = 7;
    localparam int RF_W       = 4;
    localparam int XSEL_W     = 3;
    localparam int IMM_W      = XSEL_W + REF_W;
    localparam int DATA_W     = 32;
    localparam int NUM_GREGS  = 16;
    localparam int REG_BYTE_LOG = $clog2(NUM_GREGS) + 2;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } opsize_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_INDEX = 2'd2
    } phase_e;

    typedef struct packed {
        logic              indirect;
        logic [OPC_W-1:0]  opcode;
        logic [RF_W-1:0]   rfield;
        logic [XSEL_W-1:0] xsel;
        logic [REF_W-1:0]  refaddr;
    } instr_t;

    function automatic logic is_imm_opcode(input logic [OPC_W-1:0] op);
        return (op == 7'h02) || (op[OPC_W-1:2] == 5'b01000);
    endfunction
endpackage

// File: rtl/ea_gen_decode.sv
module ea_gen_decode
    import ea_gen_pkg::*;
#(
    parameter logic [7:0] SIZE_LUT = 8'h1E
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [XSEL_W-1:0] xsel,
    input  logic [REF_W-1:0]  refaddr,
    output logic              imm_op,
    output opsize_e           size,
    output logic [DATA_W-1:0] imm_val
);
    logic [IMM_W-1:0] imm_field;

    always_comb begin
        imm_op    = is_imm_opcode(opcode);
        imm_field = {xsel, refaddr};
        imm_val   = {{(DATA_W-IMM_W){imm_field[IMM_W-1]}}, imm_field};
        if (imm_op) begin
            size = SZ_WORD;
        end else begin
            size = opsize_e'(SIZE_LUT[{opcode[1:0], 1'b0} +: 2]);
        end
    end
endmodule

// File: rtl/ea_gen_scale.sv
module ea_gen_scale
    import ea_gen_pkg::*;
(
    input  logic [REF_W-1:0]  base_word,
    input  logic [BYTE_W-1:0] index,
    input  logic              use_index,
    input  opsize_e           size,
    output logic [BYTE_W-1:0] ea,
    output logic              dw_odd
);
    logic [BYTE_W-1:0] scaled [4];
    logic [BYTE_W-1:0] offset;
    logic [BYTE_W-1:0] raw;

    for (genvar s = 0; s < 4; s++) begin : g_shift
        assign scaled[s] = index << s;
    end

    always_comb begin
        offset = use_index ? scaled[size] : '0;
        raw    = {base_word, 2'b00} + offset;
        dw_odd = (size == SZ_DWORD) && raw[2];
        ea     = (size == SZ_DWORD) ? {raw[BYTE_W-1:3], 3'b000} : raw;
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter logic [7:0] SIZE_LUT = 8'h1E
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [INSTR_W-1:0]    instr,
    output logic [XSEL_W-1:0]     rf_sel,
    input  logic [BYTE_W-1:0]     rf_data,
    output logic                  mem_req,
    output logic [REF_W-1:0]      mem_addr,
    input  logic                  mem_ack,
    input  logic [REF_W-1:0]      mem_rword,
    output logic                  done,
    output logic [BYTE_W-1:0]     ea_addr,
    output logic [1:0]            op_size,
    output logic [RF_W-1:0]       dst_reg,
    output logic                  reg_operand,
    output logic                  dw_odd,
    output logic                  is_imm,
    output logic [DATA_W-1:0]     imm_val,
    output logic                  nonexist
);
    typedef struct packed {
        phase_e             phase;
        instr_t             ins;
        logic [REF_W-1:0]   base;
        logic               done;
        logic [BYTE_W-1:0]  ea;
        opsize_e            size;
        logic [RF_W-1:0]    rdst;
        logic               regop;
        logic               odd;
        logic               imm;
        logic [DATA_W-1:0]  immv;
        logic               nonex;
    } state_t;

    state_t st_d, st_q;

    instr_t            in_word;
    instr_t            dec_src;
    logic              dec_imm;
    opsize_e           dec_size;
    logic [DATA_W-1:0] dec_immv;
    logic [REF_W-1:0]  sc_base;
    logic              sc_use_idx;
    logic [BYTE_W-1:0] sc_ea;
    logic              sc_odd;

    assign in_word = instr_t'(instr);
    assign dec_src = (st_q.phase == PH_IDLE) ? in_word : st_q.ins;

    ea_gen_decode #(.SIZE_LUT(SIZE_LUT)) u_decode (
        .opcode  (dec_src.opcode),
        .xsel    (dec_src.xsel),
        .refaddr (dec_src.refaddr),
        .imm_op  (dec_imm),
        .size    (dec_size),
        .imm_val (dec_immv)
    );

    always_comb begin
        case (st_q.phase)
            PH_FETCH: sc_base = mem_rword;
            PH_INDEX: sc_base = st_q.base;
            default:  sc_base = in_word.refaddr;
        endcase
        sc_use_idx = (st_q.phase == PH_INDEX);
    end

    ea_gen_scale u_scale (
        .base_word (sc_base),
        .index     (rf_data),
        .use_index (sc_use_idx),
        .size      (dec_size),
        .ea        (sc_ea),
        .dw_odd    (sc_odd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.ins  = in_word;
                    st_d.rdst = in_word.rfield;
                    if (dec_imm) begin
                        st_d.done  = 1'b1;
                        st_d.ea    = '0;
                        st_d.size  = SZ_WORD;
                        st_d.regop = 1'b0;
                        st_d.odd   = 1'b0;
                        st_d.imm   = 1'b1;
                        st_d.immv  = dec_immv;
                        st_d.nonex = in_word.indirect;
                    end else if (in_word.indirect) begin
                        st_d.phase = PH_FETCH;
                    end else if (in_word.xsel != '0) begin
                        st_d.base  = in_word.refaddr;
                        st_d.phase = PH_INDEX;
                    end else begin
                        st_d.done  = 1'b1;
                        st_d.ea    = sc_ea;
                        st_d.size  = dec_size;
                        st_d.regop = (sc_ea[BYTE_W-1:REG_BYTE_LOG] == '0);
                        st_d.odd   = sc_odd;
                        st_d.imm   = 1'b0;
                        st_d.immv  = '0;
                        st_d.nonex = 1'b0;
                    end
                end
            end
            PH_FETCH: begin
                if (mem_ack) begin
                    st_d.base = mem_rword;
                    if (st_q.ins.xsel != '0) begin
                        st_d.phase = PH_INDEX;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                        st_d.ea    = sc_ea;
                        st_d.size  = dec_size;
                        st_d.regop = (sc_ea[BYTE_W-1:REG_BYTE_LOG] == '0);
                        st_d.odd   = sc_odd;
                        st_d.imm   = 1'b0;
                        st_d.immv  = '0;
                        st_d.nonex = 1'b0;
                    end
                end
            end
            PH_INDEX: begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                st_d.ea    = sc_ea;
                st_d.size  = dec_size;
                st_d.regop = (sc_ea[BYTE_W-1:REG_BYTE_LOG] == '0);
                st_d.odd   = sc_odd;
                st_d.imm   = 1'b0;
                st_d.immv  = '0;
                st_d.nonex = 1'b0;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rf_sel      = (st_q.phase == PH_INDEX) ? st_q.ins.xsel : '0;
    assign mem_req     = (st_q.phase == PH_FETCH);
    assign mem_addr    = st_q.ins.refaddr;
    assign done        = st_q.done;
    assign ea_addr     = st_q.ea;
    assign op_size     = st_q.size;
    assign dst_reg     = st_q.rdst;
    assign reg_operand = st_q.regop;
    assign dw_odd      = st_q.odd;
    assign is_imm      = st_q.imm;
    assign imm_val     = st_q.immv;
    assign nonexist    = st_q.nonex;

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r8_dw_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_imm && op_size == SZ_DWORD) |-> (ea_addr[2:0] == 3'b000));

    a_r5_imm_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_imm) |-> (!$past(mem_req) && op_size == SZ_WORD && ea_addr == '0));

    a_r6_nonex_only_imm: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nonexist) |-> is_imm);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_index_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_sel != '0) |=> done);

    a_r7_reg_not_imm: assert property (@(posedge clk) disable iff (!rst_n)
        (done && reg_operand) |-> !is_imm);

    a_r10_quiet_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (!done && !mem_req));
endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] instr;
    logic [2:0]  rf_sel;
    logic [18:0] rf_data;
    logic        mem_req;
    logic [16:0] mem_addr;
    logic        mem_ack;
    logic [16:0] mem_rword;
    logic        done;
    logic [18:0] ea_addr;
    logic [1:0]  op_size;
    logic [3:0]  dst_reg;
    logic        reg_operand;
    logic        dw_odd;
    logic        is_imm;
    logic [31:0] imm_val;
    logic        nonexist;

    int total = 0;
    int bad   = 0;
    int ack_wait = 1;
    logic [18:0] rf [8];

    always #4 clk = ~clk;

    assign rf_data = rf[rf_sel];

    ea_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .rf_sel(rf_sel), .rf_data(rf_data), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rword(mem_rword),
        .done(done), .ea_addr(ea_addr), .op_size(op_size), .dst_reg(dst_reg),
        .reg_operand(reg_operand), .dw_odd(dw_odd), .is_imm(is_imm),
        .imm_val(imm_val), .nonexist(nonexist)
    );

    function automatic logic [16:0] memf(input logic [16:0] a);
        return (a * 17'd435) ^ 17'h0A5C3;
    endfunction

    function automatic logic [31:0] mk(input logic ind, input logic [6:0] op,
                                       input logic [3:0] r, input logic [2:0] x,
                                       input logic [16:0] ra);
        return {ind, op, r, x, ra};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] i);
        logic        e_imm, e_nx, e_reg, e_odd;
        logic [18:0] e_ea;
        logic [1:0]  e_sz;
        logic [31:0] e_iv;
        logic [16:0] base;
        logic [18:0] raw;
        int          cyc;
        int          e_lat;
        logic        saw_req;
        logic        ind = i[31];
        logic [6:0]  op = i[30:24];
        logic [2:0]  x = i[19:17];
        logic [16:0] ra = i[16:0];
        e_imm = (op == 7'h02) || (op >= 7'h20 && op <= 7'h23);
        e_lat = -1;
        if (e_imm) begin
            e_nx = ind; e_ea = '0; e_sz = 2'd2; e_reg = 0; e_odd = 0;
            e_iv = {{12{i[19]}}, i[19:0]}; e_lat = 1;
        end else begin
            e_nx = 0; e_iv = 0;
            case (op[1:0])
                2'd0: e_sz = 2'd2;
                2'd1: e_sz = 2'd3;
                2'd2: e_sz = 2'd1;
                default: e_sz = 2'd0;
            endcase
            base = ind ? memf(ra) : ra;
            raw = {base, 2'b00} + ((x != 0) ? (rf[x] << e_sz) : 19'd0);
            e_odd = (e_sz == 2'd3) && raw[2];
            e_ea = (e_sz == 2'd3) ? {raw[18:3], 3'b000} : raw;
            e_reg = (e_ea[18:2] < 17'd16);
            if (!ind) e_lat = (x != 0) ? 2 : 1;
        end
        @(negedge clk);
        start = 1'b1; instr = i;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        saw_req = mem_req;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (mem_req) saw_req = 1'b1;
        end
        chk(done, "R9 done seen", 32'(done), 1);
        if (e_lat > 0) chk(cyc == e_lat, "R1/R2 latency", 32'(cyc), 32'(e_lat));
        chk(is_imm == e_imm, "R5 is_imm", 32'(is_imm), 32'(e_imm));
        chk(nonexist == e_nx, "R6 nonexist", 32'(nonexist), 32'(e_nx));
        chk(ea_addr == e_ea, "R3 ea_addr", 32'(ea_addr), 32'(e_ea));
        chk(op_size == e_sz, "R3 op_size", 32'(op_size), 32'(e_sz));
        chk(dst_reg == i[23:20], "R1 dst_reg", 32'(dst_reg), 32'(i[23:20]));
        chk(reg_operand == e_reg, "R7 reg_operand", 32'(reg_operand), 32'(e_reg));
        chk(dw_odd == e_odd, "R8 dw_odd", 32'(dw_odd), 32'(e_odd));
        if (e_imm) chk(imm_val == e_iv, "R5 imm_val", imm_val, e_iv);
        chk(saw_req == (ind && !e_imm), "R4 fetch made", 32'(saw_req), 32'(ind && !e_imm));
    endtask

    initial begin
        mem_ack = 1'b0; mem_rword = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (ack_wait == 0) begin
                    mem_ack = 1'b1;
                    mem_rword = memf(mem_addr);
                    ack_wait = int'($urandom % 3);
                end else begin
                    ack_wait--;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [18:0] hold_ea;
        void'($urandom(32'd2024));
        rst_n = 1'b0; start = 1'b0; instr = '0;
        for (int k = 0; k < 8; k++) rf[k] = 19'(k * 3 + 1);
        rf[0] = 19'h00077;
        repeat (3) @(negedge clk);
        chk(!done && !mem_req, "R10 reset quiet", 32'({done, mem_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_req, "R10 after reset", 32'({done, mem_req}), 0);

        run(mk(0, 7'h30, 4'h5, 3'd0, 17'h00123));   // R1 direct word
        hold_ea = ea_addr;
        @(negedge clk);
        chk(!done && ea_addr == hold_ea, "R9 pulse and hold", 32'(ea_addr), 32'(hold_ea));
        run(mk(0, 7'h33, 4'h1, 3'd3, 17'h00200));   // R3 byte
        run(mk(0, 7'h32, 4'h2, 3'd3, 17'h00200));   // R3 halfword
        run(mk(0, 7'h30, 4'h3, 3'd3, 17'h00200));   // R3 word
        run(mk(0, 7'h31, 4'h4, 3'd3, 17'h00200));   // R3 doubleword
        run(mk(0, 7'h30, 4'h0, 3'd0, 17'h00010));   // R2 X=0 ignores rf[0]
        run(mk(0, 7'h30, 4'h0, 3'd0, 17'h0000F));   // R7 last register
        run(mk(0, 7'h30, 4'h0, 3'd0, 17'h00010));   // R7 first memory word
        run(mk(0, 7'h31, 4'h6, 3'd0, 17'h00101));   // R8 odd doubleword
        run(mk(1, 7'h30, 4'h7, 3'd0, 17'h01234));   // R4 indirect
        run(mk(1, 7'h33, 4'h7, 3'd5, 17'h01235));   // R4 indirect then index
        run(mk(0, 7'h02, 4'h1, 3'd1, 17'h00005));   // R5 positive imm
        run(mk(0, 7'h23, 4'h2, 3'd7, 17'h1FFF0));   // R5 negative imm
        run(mk(1, 7'h20, 4'h3, 3'd4, 17'h00001));   // R6 nonexistent
        rf[7] = 19'h7FFFF;
        run(mk(0, 7'h31, 4'h0, 3'd7, 17'h1FFFF));   // R3 wrap
        for (int n = 0; n < 300; n++) begin
            logic [31:0] w;
            if (n % 20 == 0)
                for (int k = 0; k < 8; k++) rf[k] = 19'($urandom);
            w = $urandom;
            if (n % 7 == 0) w[30:24] = 7'h20 + 7'($urandom % 4);
            run(w);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule